// File: doc/BRIEF.md
# Planar Video Memory Write Engine

This block turns CPU writes into stores to a four-plane video memory. Each memory word is 32 bits wide, and each plane owns one byte lane of the word. A request gives a translated offset, a flag that says the offset is valid, up to eight data bytes and a size code. The block breaks the request into byte writes and issues one per cycle, least significant byte first, at rising offsets. For each byte it drives a word address, a four-bit lane enable, a 32-bit write word, a write strobe and a done pulse.

Three addressing schemes are supported. In chained mode, byte addresses are packed four to a word. In interleaved mode, even and odd bytes are steered into plane pairs. In planar mode, one offset addresses a whole word across all four planes. Planar mode runs the full graphics write pipeline: data rotation, set/reset substitution, a logic operation against the latch, a bit mask that merges the result with the latch, and per-plane enables from the map mask. Four write modes choose how the data and the bit mask are formed.

The control is a two-state machine. `ST_IDLE` raises `req_ready` and waits. `req_valid` takes it to `ST_WRITE` and the request is captured. `ST_WRITE` pulses `wr_done` once for each byte, moves to the next byte while the count is below the last index, and goes back to `ST_IDLE` after the last byte. The configuration and latch inputs must be held stable while a request is running.

Top module: `vga_plane_writer`

## Requirements
- R1: After reset the block is in `ST_IDLE`: `req_ready` is 1, and `wr_done`, `mem_we` and `mem_lane_en` are 0.
- R2: When `req_offset_ok` is 0 the request still produces its done pulses, but `mem_we` and `mem_lane_en` stay 0 for every byte.
- R3: Chained mode (`cfg_chain4`=1): the plane is offset bits 1:0, the word address is the offset shifted right by 2, and the write word is the byte copied into all four lanes. The single lane `1<<plane` is enabled only when `cfg_map_mask[plane]` is 1.
- R4: Interleaved mode (`cfg_odd_even`=1, `cfg_chain4`=0): the plane is {`cfg_plane_hi`, offset bit 0}, and the word address is the offset shifted right by 1 (this is byte address ((offset & ~1) << 1) | plane, divided by 4). The write word and the map-mask gating are the same as in R3.
- R5: Planar write mode 0 (`cfg_write_mode`=0): the byte is rotated right by `cfg_rotate` and placed in every plane. A plane whose `cfg_sr_enable` bit is 1 takes eight copies of its `cfg_sr_value` bit instead. The bit mask is `cfg_bit_mask`.
- R6: Planar write mode 1: the write word is `latch_in`, and the logic operation and bit mask are skipped.
- R7: Planar write mode 2: plane p gets eight copies of CPU byte bit p. The bit mask is `cfg_bit_mask`.
- R8: Planar write mode 3: the bit mask is the rotated byte ANDed with `cfg_bit_mask`. Plane p gets eight copies of `cfg_sr_value[p]`.
- R9: In planar modes 0, 2 and 3, `cfg_logic_op` combines the data with the latch: 0 passes the data, 1 is AND, 2 is OR, 3 is XOR.
- R10: The bit mask applies to every plane. Mask bits that are 1 take the combined data, and mask bits that are 0 take the latch bit.
- R11: Planar mode: the word address is the offset, and `mem_lane_en` equals `cfg_map_mask`. `mem_we` is 1 exactly when at least one lane is enabled.
- R12: `req_size` 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Byte i is issued in cycle i after acceptance at offset+i, using data bits 8i+7:8i. `req_ready` is 0 until the last byte has been issued.
- R13: Chained mode takes precedence over interleaved mode. Planar mode applies only when both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken in ST_IDLE |
| req_ready | output | 1 | High in ST_IDLE |
| req_offset | input | OFS_W | Translated start offset |
| req_offset_ok | input | 1 | Offset is valid |
| req_data | input | 8*MAX_BYTES | Data bytes, LSB first |
| req_size | input | 2 | Size code, byte count = 1 << code |
| cfg_chain4 | input | 1 | Chained addressing |
| cfg_odd_even | input | 1 | Interleaved addressing |
| cfg_plane_hi | input | 1 | Upper plane-select bit in interleaved mode |
| cfg_map_mask | input | 4 | Per-plane write enable |
| cfg_write_mode | input | 2 | Planar write mode |
| cfg_rotate | input | 3 | Right-rotate count |
| cfg_logic_op | input | 2 | Logic operation against latch |
| cfg_sr_value | input | 4 | Set/reset value per plane |
| cfg_sr_enable | input | 4 | Set/reset enable per plane |
| cfg_bit_mask | input | 8 | Bit mask |
| latch_in | input | 32 | Latched memory word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | OFS_W | Word address |
| mem_lane_en | output | 4 | Byte-lane enable, one per plane |
| mem_wdata | output | 32 | Write word |
| wr_done | output | 1 | One pulse per byte write |

## Verification
The bench builds the block with OFS_W=8 and MAX_BYTES=8. The narrow offset lets short runs of chained and interleaved writes reach the top of the offset range, so wraparound of rising offsets is covered. The full eight-byte size code remains usable. Planar mode is swept over every write mode, logic operation and rotate count, with two data patterns. Set/reset, bit-mask and map-mask values are derived from the loop indices, so partial lane enables and set/reset substitution are both reached.

// File: rtl/vga_wr_pkg.sv
package vga_wr_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_XOR  = 2'd3
    } alu_op_e;
endpackage

// File: rtl/vga_wr_planar.sv
module vga_wr_planar
    import vga_wr_pkg::*;
(
    input  logic [BYTE_W-1:0] cpu_byte,
    input  logic [1:0]        write_mode,
    input  logic [2:0]        rotate,
    input  logic [1:0]        logic_op,
    input  logic [LANES-1:0]  sr_value,
    input  logic [LANES-1:0]  sr_enable,
    input  logic [BYTE_W-1:0] bit_mask,
    input  logic [WORD_W-1:0] latch,
    output logic [WORD_W-1:0] word
);
    logic [2*BYTE_W-1:0] dbl;
    logic [BYTE_W-1:0]   rot_byte;
    logic [BYTE_W-1:0]   eff_mask;
    alu_op_e             op;

    assign dbl      = {cpu_byte, cpu_byte} >> rotate;
    assign rot_byte = dbl[BYTE_W-1:0];
    assign eff_mask = (write_mode == 2'd3) ? (bit_mask & rot_byte) : bit_mask;
    assign op       = alu_op_e'(logic_op);

    for (genvar p = 0; p < LANES; p++) begin : g_plane
        logic [BYTE_W-1:0] lat;
        logic [BYTE_W-1:0] src;
        logic [BYTE_W-1:0] alu;

        assign lat = latch[p*BYTE_W +: BYTE_W];

        always_comb begin
            unique case (write_mode)
                2'd0:    src = sr_enable[p] ? {BYTE_W{sr_value[p]}} : rot_byte;
                2'd1:    src = lat;
                2'd2:    src = {BYTE_W{cpu_byte[p]}};
                default: src = {BYTE_W{sr_value[p]}};
            endcase
        end

        always_comb begin
            unique case (op)
                OP_PASS: alu = src;
                OP_AND:  alu = src & lat;
                OP_OR:   alu = src | lat;
                default: alu = src ^ lat;
            endcase
        end

        assign word[p*BYTE_W +: BYTE_W] = (write_mode == 2'd1) ? lat
                                        : ((alu & eff_mask) | (lat & ~eff_mask));
    end
endmodule

// File: rtl/vga_wr_route.sv
module vga_wr_route
    import vga_wr_pkg::*;
#(
    parameter int OFS_W = 17
) (
    input  logic              enable,
    input  logic [OFS_W-1:0]  offset,
    input  logic [BYTE_W-1:0] cpu_byte,
    input  logic              chain4,
    input  logic              odd_even,
    input  logic              plane_hi,
    input  logic [LANES-1:0]  map_mask,
    input  logic [WORD_W-1:0] planar_word,
    output logic              we,
    output logic [OFS_W-1:0]  addr,
    output logic [LANES-1:0]  lane_en,
    output logic [WORD_W-1:0] wdata
);
    logic [1:0] plane;

    always_comb begin
        plane   = 2'd0;
        addr    = offset;
        lane_en = '0;
        wdata   = {LANES{cpu_byte}};
        if (chain4) begin
            plane = offset[1:0];
            addr  = offset >> 2;
            if (enable && map_mask[plane]) lane_en = LANES'(1) << plane;
        end else if (odd_even) begin
            plane = {plane_hi, offset[0]};
            addr  = offset >> 1;
            if (enable && map_mask[plane]) lane_en = LANES'(1) << plane;
        end else begin
            wdata = planar_word;
            if (enable) lane_en = map_mask;
        end
    end

    assign we = |lane_en;
endmodule

// File: rtl/vga_plane_writer.sv
module vga_plane_writer
    import vga_wr_pkg::*;
#(
    parameter int OFS_W     = 17,
    parameter int MAX_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [OFS_W-1:0]       req_offset,
    input  logic                   req_offset_ok,
    input  logic [8*MAX_BYTES-1:0] req_data,
    input  logic [1:0]             req_size,
    input  logic                   cfg_chain4,
    input  logic                   cfg_odd_even,
    input  logic                   cfg_plane_hi,
    input  logic [3:0]             cfg_map_mask,
    input  logic [1:0]             cfg_write_mode,
    input  logic [2:0]             cfg_rotate,
    input  logic [1:0]             cfg_logic_op,
    input  logic [3:0]             cfg_sr_value,
    input  logic [3:0]             cfg_sr_enable,
    input  logic [7:0]             cfg_bit_mask,
    input  logic [31:0]            latch_in,
    output logic                   mem_we,
    output logic [OFS_W-1:0]       mem_addr,
    output logic [3:0]             mem_lane_en,
    output logic [31:0]            mem_wdata,
    output logic                   wr_done
);
    localparam int DATA_W = BYTE_W * MAX_BYTES;
    localparam int CNT_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    wr_state_e              state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       last_q;
    logic [OFS_W-1:0]       off_q;
    logic                   ok_q;
    logic [DATA_W-1:0]      data_q;
    logic [BYTE_W-1:0]      cur_byte;
    logic [OFS_W-1:0]       cur_off;
    logic [WORD_W-1:0]      planar_word;

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
            off_q   <= '0;
            ok_q    <= 1'b0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_WRITE;
                        cnt_q   <= '0;
                        last_q  <= CNT_W'((1 << req_size) - 1);
                        off_q   <= req_offset;
                        ok_q    <= req_offset_ok;
                        data_q  <= req_data;
                    end
                end
                ST_WRITE: begin
                    if (cnt_q == last_q) begin
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs from state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                wr_done   = 1'b0;
            end
            default: begin
                req_ready = 1'b0;
                wr_done   = 1'b1;
            end
        endcase
    end

    assign cur_byte = data_q[cnt_q*BYTE_W +: BYTE_W];
    assign cur_off  = off_q + OFS_W'(cnt_q);

    vga_wr_planar u_planar (
        .cpu_byte   (cur_byte),
        .write_mode (cfg_write_mode),
        .rotate     (cfg_rotate),
        .logic_op   (cfg_logic_op),
        .sr_value   (cfg_sr_value),
        .sr_enable  (cfg_sr_enable),
        .bit_mask   (cfg_bit_mask),
        .latch      (latch_in),
        .word       (planar_word)
    );

    vga_wr_route #(.OFS_W(OFS_W)) u_route (
        .enable      (wr_done && ok_q),
        .offset      (cur_off),
        .cpu_byte    (cur_byte),
        .chain4      (cfg_chain4),
        .odd_even    (cfg_odd_even),
        .plane_hi    (cfg_plane_hi),
        .map_mask    (cfg_map_mask),
        .planar_word (planar_word),
        .we          (mem_we),
        .addr        (mem_addr),
        .lane_en     (mem_lane_en),
        .wdata       (mem_wdata)
    );

    assert_write_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_done);

    assert_invalid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !ok_q) |-> (!mem_we && mem_lane_en == 4'd0));

    assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (cfg_chain4 || cfg_odd_even)) |-> ($countones(mem_lane_en) == 1));

    assert_lane_in_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lane_en & ~cfg_map_mask) == 4'd0);

    assert_ready_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && wr_done));

    assert_byte_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && cnt_q != last_q) |=>
        (state_q == ST_WRITE && cnt_q == CNT_W'($past(cnt_q) + 1)));
endmodule

// File: tb/tb_vga_plane_writer.sv
`timescale 1ns/1ps
module tb_vga_plane_writer;
    localparam int OFS_W = 8;
    localparam int MAXB  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [OFS_W-1:0]  req_offset = '0;
    logic              req_offset_ok = 1'b0;
    logic [8*MAXB-1:0] req_data = '0;
    logic [1:0]        req_size = '0;
    logic              cfg_chain4 = 1'b0, cfg_odd_even = 1'b0, cfg_plane_hi = 1'b0;
    logic [3:0]        cfg_map_mask = 4'hF;
    logic [1:0]        cfg_write_mode = '0;
    logic [2:0]        cfg_rotate = '0;
    logic [1:0]        cfg_logic_op = '0;
    logic [3:0]        cfg_sr_value = '0, cfg_sr_enable = '0;
    logic [7:0]        cfg_bit_mask = 8'hFF;
    logic [31:0]       latch_in = '0;
    logic              mem_we;
    logic [OFS_W-1:0]  mem_addr;
    logic [3:0]        mem_lane_en;
    logic [31:0]       mem_wdata;
    logic              wr_done;

    vga_plane_writer #(.OFS_W(OFS_W), .MAX_BYTES(MAXB)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_offset_ok(req_offset_ok), .req_data(req_data),
        .req_size(req_size), .cfg_chain4(cfg_chain4), .cfg_odd_even(cfg_odd_even),
        .cfg_plane_hi(cfg_plane_hi), .cfg_map_mask(cfg_map_mask),
        .cfg_write_mode(cfg_write_mode), .cfg_rotate(cfg_rotate),
        .cfg_logic_op(cfg_logic_op), .cfg_sr_value(cfg_sr_value),
        .cfg_sr_enable(cfg_sr_enable), .cfg_bit_mask(cfg_bit_mask),
        .latch_in(latch_in), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_lane_en(mem_lane_en), .mem_wdata(mem_wdata), .wr_done(wr_done)
    );

    int total = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Planar word from R5..R10
    function automatic logic [31:0] model_planar(logic [7:0] b);
        logic [7:0]  r, m, s, l, a;
        logic [31:0] w;
        r = 8'((({b, b}) >> cfg_rotate) & 16'hFF);
        m = (cfg_write_mode == 2'd3) ? (cfg_bit_mask & r) : cfg_bit_mask;
        for (int p = 0; p < 4; p++) begin
            l = latch_in[p*8 +: 8];
            case (cfg_write_mode)
                2'd0: s = cfg_sr_enable[p] ? (cfg_sr_value[p] ? 8'hFF : 8'h00) : r;
                2'd2: s = b[p] ? 8'hFF : 8'h00;
                default: s = cfg_sr_value[p] ? 8'hFF : 8'h00;
            endcase
            case (cfg_logic_op)
                2'd0: a = s;
                2'd1: a = s & l;
                2'd2: a = s | l;
                default: a = s ^ l;
            endcase
            w[p*8 +: 8] = (cfg_write_mode == 2'd1) ? l : ((a & m) | (l & ~m));
        end
        return w;
    endfunction

    task automatic run_req(string tag, logic [7:0] off, logic ok,
                           logic [63:0] data, logic [1:0] size);
        int n;
        logic [7:0]  o, b;
        logic [1:0]  pl;
        logic [3:0]  lanes;
        logic [7:0]  addr;
        logic [31:0] wd;
        n = 1 << size;
        @(negedge clk);
        req_offset = off; req_offset_ok = ok; req_data = data; req_size = size;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            o = off + 8'(i);
            b = data[i*8 +: 8];
            lanes = 4'd0;
            wd = {4{b}};
            if (cfg_chain4) begin
                pl = o[1:0]; addr = o >> 2;
                if (ok && cfg_map_mask[pl]) lanes = 4'd1 << pl;
            end else if (cfg_odd_even) begin
                pl = {cfg_plane_hi, o[0]};
                addr = 8'((({1'b0, o} & 9'h1FE) << 1 | 9'(pl)) >> 2);
                if (ok && cfg_map_mask[pl]) lanes = 4'd1 << pl;
            end else begin
                addr = o; wd = model_planar(b);
                if (ok) lanes = cfg_map_mask;
            end
            chk({tag, " R12 done"}, 64'(wr_done), 64'd1);
            chk({tag, " R12 ready low"}, 64'(req_ready), 64'd0);
            chk({tag, " lanes"}, 64'(mem_lane_en), 64'(lanes));
            chk({tag, " we"}, 64'(mem_we), 64'(lanes != 4'd0));
            if (lanes != 4'd0) begin
                chk({tag, " addr"}, 64'(mem_addr), 64'(addr));
                chk({tag, " wdata"}, 64'(mem_wdata), 64'(wd));
            end
            @(negedge clk);
        end
        chk({tag, " R12 back to idle"}, 64'({req_ready, wr_done}), 64'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 done", 64'(wr_done), 64'd0);
        chk("R1 we", 64'(mem_we), 64'd0);
        chk("R1 lanes", 64'(mem_lane_en), 64'd0);

        // Planar sweep
        for (int wm = 0; wm < 4; wm++)
            for (int op = 0; op < 4; op++)
                for (int rt = 0; rt < 8; rt++)
                    for (int pt = 0; pt < 2; pt++) begin
                        cfg_write_mode = 2'(wm);
                        cfg_logic_op   = 2'(op);
                        cfg_rotate     = 3'(rt);
                        cfg_sr_value   = 4'(4'b0101 ^ rt);
                        cfg_sr_enable  = 4'(4'b0011 << (rt & 2)) ^ 4'(pt);
                        cfg_bit_mask   = 8'hF0 ^ 8'(rt * 8'h13);
                        cfg_map_mask   = (rt == 7) ? 4'b1010 : ((rt == 6) ? 4'b0001 : 4'hF);
                        latch_in       = 32'h1234_5678 ^ {4{pt ? 8'hC3 : 8'h5A}};
                        run_req($sformatf("R5 R6 R7 R8 R9 R10 R11 wm%0d op%0d", wm, op),
                                8'(rt * 5 + wm), 1'b1,
                                64'(pt ? 8'h3C : 8'hA5), 2'd0);
                    end

        // Multi-byte planar
        cfg_write_mode = 2'd2; cfg_logic_op = 2'd0; cfg_map_mask = 4'hF; cfg_bit_mask = 8'h0F;
        for (int sz = 0; sz < 4; sz++)
            run_req("R12 R7 planar size", 8'hFA, 1'b1, 64'h0F1E_2D3C_4B5A_6978, 2'(sz));

        // Chained mode
        cfg_chain4 = 1'b1; cfg_odd_even = 1'b0; cfg_map_mask = 4'b1011;
        for (int o = 0; o < 16; o += 4)
            run_req("R3 chain", 8'(o + 8'hF0), 1'b1, 64'hDEAD_BEEF_0123_4567 ^ 64'(o), 2'd2);
        run_req("R3 R12 chain8", 8'hFC, 1'b1, 64'h8877_6655_4433_2211, 2'd3);

        // Precedence: both flags set
        cfg_odd_even = 1'b1;
        run_req("R13 chain over interleave", 8'h05, 1'b1, 64'h0000_0000_99AA_BBCC, 2'd2);

        // Interleaved mode
        cfg_chain4 = 1'b0; cfg_map_mask = 4'b0110;
        for (int h = 0; h < 2; h++) begin
            cfg_plane_hi = 1'(h);
            run_req("R4 interleave", 8'(h * 8'h41), 1'b1, 64'h1122_3344_5566_7788, 2'd3);
        end

        // Invalid offset
        run_req("R2 interleave invalid", 8'h10, 1'b0, 64'h55AA, 2'd1);
        cfg_chain4 = 1'b1; cfg_map_mask = 4'hF;
        run_req("R2 chain invalid", 8'h20, 1'b0, 64'h1234_5678, 2'd2);
        cfg_chain4 = 1'b0; cfg_odd_even = 1'b0;
        run_req("R2 planar invalid", 8'h30, 1'b0, 64'hFF, 2'd0);
        run_req("R13 planar after flags clear", 8'h31, 1'b1, 64'h81, 2'd0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule